// File: doc/BRIEF.md
# Receive Frame Buffer with Batch Threshold and Flow Control

This block sits between a serial receiver's shift logic and software. Each time the receiver reports a finished frame, the word is queued only if it arrived without a parity or framing fault. Software reads words out oldest first. A ready flag tells software a batch is waiting. The flag rises when the number of queued words reaches a programmable threshold, or when the line has been quiet for longer than a fixed number of baud ticks while a partial batch is left in the queue.

The block also drives the request-to-send output used for hardware flow control. The output rises as the last data bit of a frame arrives. It falls again at the stop bit unless that frame completed a batch, in which case it is held until software has emptied the queue. With queueing switched off, the block acts as a single holding register with a threshold of one.

Top module: `rxq_ctl`

## Requirements
- R1: After reset or a one-cycle `soft_clr`, `count` is 0 and `ready`, `rts`, `ovr_flag` and `err_flag` are 0.
- R2: A `stop_det` pulse with `rx_en`=1 and both error inputs low stores `rx_word`. `rd_data` always shows the oldest stored word. A `rd_en` pulse removes that word. `count` gives the number of stored words one cycle after the strobe.
- R3: With `fifo_en`=1, `ready` becomes 1 in the cycle after a store brings `count` up to `thresh`. Values 0 and above 16 are taken as 1 and 16. `ready` returns to 0 in the cycle after the read that empties the queue.
- R4: With `fifo_en`=1, `idle_en`=1, 0 < `count` < threshold and `line_busy`=0, `ready` becomes 1 after the ninth `baud_tick` of quiet line, which is more than 8 baud clocks.
- R5: A read, a `stop_det` or `line_busy`=1 during the quiet-line count restarts it from zero. With `idle_en`=0 or `fifo_en`=0, quiet-line time never sets `ready`.
- R6: A frame with `par_err` or `frm_err` is not stored, does not set `ready`, and sets `err_flag`. While `err_flag` or `ovr_flag` is 1, no frame is stored. `err_clr` clears both flags.
- R7: A good frame that arrives while the queue is full (16 words, or 1 with `fifo_en`=0) is dropped, and it sets `ovr_flag` and `ready`.
- R8: With `flow_en`=1 and `rx_en`=1, `rts` is 1 in the cycle after a `pre_stop` pulse.
- R9: With `fifo_en`=1, `rts` falls after `stop_det` if `count` is then below the threshold. Otherwise it stays 1 until the read that empties the queue.
- R10: A `ready` raised only by the quiet-line timeout leaves `rts` at 0.
- R11: `rts` is 0 whenever `flow_en`=0 or `rx_en`=0. A `soft_clr` or a period with `rx_en`=0 drops a pending request.
- R12: With `fifo_en`=0, one word is held and `ready` sets on it. `rts` rises at `pre_stop`, stays 1 past the stop bit, and falls after that word is read.
- R13: A `rd_en` pulse while `count` is 0 has no effect: `count` stays 0 and `ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr | input | 1 | Synchronous clear of queue, flags and request |
| rx_en | input | 1 | Receive enable |
| fifo_en | input | 1 | 1: 16-word queue; 0: single holding register |
| flow_en | input | 1 | Enables the `rts` output |
| idle_en | input | 1 | Enables the quiet-line timeout |
| thresh | input | 5 | Batch size that raises `ready` |
| line_busy | input | 1 | Receiver is inside a frame |
| baud_tick | input | 1 | One pulse per baud clock |
| pre_stop | input | 1 | Pulse when the bit before the stop bit is received |
| stop_det | input | 1 | Pulse when the stop bit is detected; qualifies word and errors |
| rx_word | input | 9 | Received word |
| par_err | input | 1 | Parity fault on this frame |
| frm_err | input | 1 | Framing fault on this frame |
| rd_en | input | 1 | Pop the oldest word |
| err_clr | input | 1 | Clear `err_flag` and `ovr_flag` |
| rd_data | output | 9 | Oldest stored word |
| count | output | 5 | Words stored |
| ready | output | 1 | Batch ready for software |
| rts | output | 1 | Flow-control request, 1 = pause sender |
| ovr_flag | output | 1 | A frame was lost because the queue was full |
| err_flag | output | 1 | A parity or framing fault occurred |

## Verification
The bench targets the cases where the request output has to tell a batch-completing frame from an ordinary one. A design that dropped `rts` at every stop bit, or held it after each frame, would fail there. The bench also sets up a quiet-line timeout with a read partway through the count. A design that kept counting across the read raises `ready` too early, and one that counted to only 8 ticks raises it one tick early. Faulty frames followed by good ones check that a design does not keep storing while the error flag is set. A frame sent into a full queue, in both modes, checks that the stored words are not corrupted and that the overrun raises `ready`.

// File: rtl/rxq_ctl.sv
module rxq_ctl #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 9,
  parameter int IDLE_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             rx_en,
  input  logic             fifo_en,
  input  logic             flow_en,
  input  logic             idle_en,
  input  logic [$clog2(DEPTH):0] thresh,
  input  logic             line_busy,
  input  logic             baud_tick,
  input  logic             pre_stop,
  input  logic             stop_det,
  input  logic [WIDTH-1:0] rx_word,
  input  logic             par_err,
  input  logic             frm_err,
  input  logic             rd_en,
  input  logic             err_clr,
  output logic [WIDTH-1:0] rd_data,
  output logic [$clog2(DEPTH):0] count,
  output logic             ready,
  output logic             rts,
  output logic             ovr_flag,
  output logic             err_flag
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int TW = $clog2(IDLE_TICKS + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nx, thr_eff, cap;
  logic [TW-1:0] idle_cnt;
  logic rts_q;

  always_comb begin
    if (!fifo_en)                 thr_eff = CW'(1);
    else if (thresh == '0)        thr_eff = CW'(1);
    else if (thresh > CW'(DEPTH)) thr_eff = CW'(DEPTH);
    else                          thr_eff = thresh;
  end

  assign cap = fifo_en ? CW'(DEPTH) : CW'(1);

  wire frame_in = stop_det & rx_en;
  wire bad      = par_err | frm_err;
  wire frame_ok = frame_in & ~bad & ~err_flag & ~ovr_flag;
  wire full     = cnt >= cap;
  wire push     = frame_ok & ~full;
  wire ovr_hit  = frame_ok & full;
  wire pop      = rd_en & (cnt != '0);
  wire thr_hit  = push & (cnt_nx >= thr_eff);

  assign cnt_nx = cnt + CW'(push) - CW'(pop);

  wire idle_run = fifo_en & idle_en & (cnt != '0) & (cnt < thr_eff)
                & ~ready & ~line_busy & ~rd_en & ~stop_det;
  wire idle_hit = idle_run & baud_tick & (idle_cnt == TW'(IDLE_TICKS));

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (soft_clr) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   idle_cnt <= '0;
    else if (soft_clr | ~idle_run) idle_cnt <= '0;
    else if (baud_tick)
      idle_cnt <= (idle_cnt == TW'(IDLE_TICKS)) ? '0 : idle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               ready <= 1'b0;
    else if (soft_clr)                        ready <= 1'b0;
    else if (thr_hit | ovr_hit | idle_hit)    ready <= 1'b1;
    else if (cnt_nx == '0)                    ready <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0; ovr_flag <= 1'b0;
    end else if (soft_clr) begin
      err_flag <= 1'b0; ovr_flag <= 1'b0;
    end else begin
      if (frame_in & bad)  err_flag <= 1'b1;
      else if (err_clr)    err_flag <= 1'b0;
      if (ovr_hit)         ovr_flag <= 1'b1;
      else if (err_clr)    ovr_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rts_q <= 1'b0;
    else if (soft_clr | ~rx_en)   rts_q <= 1'b0;
    else if (pre_stop)            rts_q <= 1'b1;
    else if (stop_det)            rts_q <= (cnt_nx >= thr_eff);
    else if (pop & cnt_nx == '0)  rts_q <= 1'b0;
  end

  assign rts     = rts_q & flow_en & rx_en;
  assign count   = cnt;
  assign rd_data = mem[rp];
endmodule

// File: rtl/rxq_ctl_chk.sv
module rxq_ctl_chk #(
  parameter int DEPTH = 16
) (
  input logic clk,
  input logic rst_n,
  input logic soft_clr,
  input logic rx_en,
  input logic flow_en,
  input logic fifo_en,
  input logic pre_stop,
  input logic stop_det,
  input logic par_err,
  input logic frm_err,
  input logic rd_en,
  input logic err_clr,
  input logic [$clog2(DEPTH):0] count,
  input logic ready,
  input logic rts,
  input logic ovr_flag,
  input logic err_flag
);
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH)+1)'(DEPTH));

  // R6
  bad_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && rx_en && (par_err || frm_err)) |=> (count <= $past(count)));

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> (count == '0));

  // R7
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && rx_en && fifo_en && !par_err && !frm_err && !err_flag
     && count == ($clog2(DEPTH)+1)'(DEPTH) && !rd_en && !soft_clr && !err_clr)
    |=> (ovr_flag && ready));

  // R8
  rts_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rts) && $past(flow_en) && $past(rx_en)) |-> $past(pre_stop));

  // R11
  rts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !rts);

  // R13
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && count == '0 && !stop_det) |=> (count == '0));
endmodule

bind rxq_ctl rxq_ctl_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .rx_en(rx_en),
  .flow_en(flow_en), .fifo_en(fifo_en), .pre_stop(pre_stop),
  .stop_det(stop_det), .par_err(par_err), .frm_err(frm_err),
  .rd_en(rd_en), .err_clr(err_clr), .count(count), .ready(ready),
  .rts(rts), .ovr_flag(ovr_flag), .err_flag(err_flag)
);

// File: tb/rxq_ctl_test.sv
module rxq_ctl_test;
  logic clk = 0, rst_n = 0, soft_clr = 0, rx_en = 1, fifo_en = 1, flow_en = 1;
  logic idle_en = 0, line_busy = 0, baud_tick = 0, pre_stop = 0, stop_det = 0;
  logic par_err = 0, frm_err = 0, rd_en = 0, err_clr = 0;
  logic [4:0] thresh = 5'd1;
  logic [8:0] rx_word = '0;
  logic [8:0] rd_data;
  logic [4:0] count;
  logic ready, rts, ovr_flag, err_flag;
  int checks = 0, errors = 0;
  logic rts_mid;

  always #2 clk = ~clk;

  rxq_ctl uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic send(input logic [8:0] w, input logic pe, input logic fe);
    cyc(); pre_stop = 1;
    cyc(); pre_stop = 0;
    cyc(); rts_mid = rts;
    stop_det = 1; rx_word = w; par_err = pe; frm_err = fe;
    cyc(); stop_det = 0; par_err = 0; frm_err = 0;
  endtask

  task automatic rd(); cyc(); rd_en = 1; cyc(); rd_en = 0; endtask
  task automatic tick(); cyc(); baud_tick = 1; cyc(); baud_tick = 0; endtask
  task automatic clr_err(); cyc(); err_clr = 1; cyc(); err_clr = 0; endtask

  task automatic t_reset();
    chk("R1 count", count, 0); chk("R1 ready", ready, 0);
    chk("R1 rts", rts, 0); chk("R1 ovr", ovr_flag, 0); chk("R1 err", err_flag, 0);
  endtask

  task automatic t_batch();
    fifo_en = 1; flow_en = 1; thresh = 3;
    send(9'h0A1, 0, 0);
    chk("R8 rts after pre_stop", rts_mid, 1);
    chk("R9 rts drops below thr", rts, 0);
    chk("R2 count", count, 1); chk("R3 no early ready", ready, 0);
    send(9'h152, 0, 0);
    chk("R2 count", count, 2);
    send(9'h0C3, 0, 0);
    chk("R3 ready at thr", ready, 1); chk("R9 rts held", rts, 1);
    chk("R2 head", rd_data, 9'h0A1);
    rd();
    chk("R2 count after read", count, 2); chk("R9 rts held", rts, 1);
    chk("R2 head", rd_data, 9'h152);
    rd();
    chk("R2 head", rd_data, 9'h0C3);
    rd();
    chk("R3 ready clear", ready, 0); chk("R9 rts released", rts, 0);
    chk("R2 empty", count, 0);
  endtask

  task automatic t_idle();
    fifo_en = 1; thresh = 4; idle_en = 1;
    send(9'h011, 0, 0); send(9'h022, 0, 0);
    repeat (5) tick();
    rd();
    chk("R5 count after read", count, 1);
    repeat (8) tick();
    chk("R5 restart after read", ready, 0);
    tick();
    chk("R4 idle ready", ready, 1);
    chk("R10 rts stays low", rts, 0);
    rd();
    chk("R3 ready clears", ready, 0);
    idle_en = 0;
    send(9'h033, 0, 0);
    repeat (12) tick();
    chk("R5 idle disabled", ready, 0);
    rd();
  endtask

  task automatic t_error();
    fifo_en = 1; thresh = 2;
    send(9'h0EE, 1, 0);
    chk("R6 parity not stored", count, 0);
    chk("R6 err flag", err_flag, 1); chk("R6 no ready", ready, 0);
    send(9'h044, 0, 0);
    chk("R6 blocked while flag", count, 0);
    clr_err();
    chk("R6 flag cleared", err_flag, 0);
    send(9'h055, 0, 0);
    chk("R6 stored after clear", count, 1);
    send(9'h066, 0, 1);
    chk("R6 framing not stored", count, 1);
    chk("R6 err flag", err_flag, 1);
    clr_err(); rd();
  endtask

  task automatic t_overrun();
    fifo_en = 1; thresh = 16;
    for (int i = 0; i < 16; i++) send(9'(i + 9'h100), 0, 0);
    chk("R3 ready at 16", ready, 1);
    send(9'h1FF, 0, 0);
    chk("R7 ovr flag", ovr_flag, 1); chk("R7 count", count, 16);
    chk("R7 ready", ready, 1);
    for (int i = 0; i < 16; i++) begin
      chk("R7 data kept", rd_data, i + 9'h100);
      rd();
    end
    chk("R3 ready after drain", ready, 0);
    clr_err();
  endtask

  task automatic t_force();
    flow_en = 0;
    cyc(); pre_stop = 1; cyc(); pre_stop = 0;
    chk("R11 flow off", rts, 0);
    flow_en = 1;
    cyc(); pre_stop = 1; cyc(); pre_stop = 0;
    chk("R8 rts", rts, 1);
    rx_en = 0; #1;
    chk("R11 rx off", rts, 0);
    cyc(); rx_en = 1; cyc();
    chk("R11 request dropped", rts, 0);
    cyc(); pre_stop = 1; cyc(); pre_stop = 0;
    soft_clr = 1; cyc(); soft_clr = 0;
    chk("R11 soft clear", rts, 0);
    chk("R1 soft clear count", count, 0);
  endtask

  task automatic t_single();
    fifo_en = 0; flow_en = 1; thresh = 5;
    send(9'h0AB, 0, 0);
    chk("R12 rts at pre_stop", rts_mid, 1);
    chk("R12 ready", ready, 1); chk("R12 rts held", rts, 1);
    send(9'h0CD, 0, 0);
    chk("R12 overrun", ovr_flag, 1); chk("R12 count", count, 1);
    chk("R12 data", rd_data, 9'h0AB);
    rd();
    chk("R12 rts released", rts, 0); chk("R12 ready clear", ready, 0);
    clr_err();
    fifo_en = 1;
  endtask

  task automatic t_empty_read();
    rd();
    chk("R13 count", count, 0); chk("R13 ready", ready, 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_batch();
    t_idle();
    t_error();
    t_overrun();
    t_force();
    t_single();
    t_empty_read();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule